// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the 32-bit unsigned product of two 16-bit unsigned operands. It reuses one small adder tree over several clock cycles instead of building a full array multiplier. Each cycle it adds the partial products selected by the low multiplier bits to a running sum. The multiplicand is kept in a register that shifts left, and the multiplier is kept in a register that shifts right.

A parameter sets how many partial products are summed per cycle. With one per cycle, a product takes 16 accumulation cycles. With two per cycle, it takes 8, at the cost of a second adder input.

The environment raises `start_i` with valid operands and keeps it high. When the product is ready, the block raises `done_o` and holds both `done_o` and `result_o` until `start_i` is released. After that it returns to idle and can accept the next operation.

Top module: `shift_add_mul`

## Requirements
- R1: `result_o` equals the unsigned product `a_i * b_i` of the operands captured at the start of the operation whenever `done_o` is high.
- R2: With `ADDS_PER_CYC = 1`, `done_o` rises at the 17th rising clock edge counted from the edge at which `start_i` is first sampled high in idle. That edge captures the operands and is followed by 16 accumulation edges.
- R3: With `ADDS_PER_CYC = 2`, `done_o` rises at the 9th such edge. Accumulation step k adds the partial products for multiplier bits 2k and 2k+1 together.
- R4: While `done_o` is high and `start_i` stays high, `done_o` remains high and `result_o` does not change.
- R5: On the first edge at which `start_i` is sampled low while `done_o` is high, `done_o` falls and the block returns to idle. A `start_i` sampled high on the following edge starts a new operation with the full latency.
- R6: Operand inputs are sampled only on the capture edge. Changing `a_i` or `b_i` during the accumulation cycles has no effect on the result.
- R7: Asserting `rst_ni` low, including in the middle of an operation, forces `done_o` to 0 and `result_o` to 0 at once, and returns the block to idle.
- R8: Zero operands and all-ones operands give the exact product (0xFFFF × 0xFFFF = 0xFFFE0001) with the same full cycle count as any other operands.
- R9: While idle with `start_i` low, `done_o` stays 0 and `result_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request, held high until done is seen |
| a_i | input | 16 | Multiplicand, unsigned |
| b_i | input | 16 | Multiplier, unsigned |
| result_o | output | 32 | Product |
| done_o | output | 1 | Product valid, held while start is high |

## Verification
Two events can fall on the same edge: the release of `start_i` and the rise of `done_o`. A second pair can also coincide: the fall of `done_o` and a new `start_i` capture. The bench provokes the first pair by dropping `start_i` in the very cycle `done_o` is first seen high, and then expects `done_o` low after exactly one edge. It provokes the second pair by raising `start_i` again in the same cycle `done_o` is seen low. That second operation is judged on both its product and its full latency, so a lost or doubled capture shows up as a wrong count or a wrong value.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_HOLD = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned STEPS = 16,
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);

  mul_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_step;

  assign last_step = (cnt_q == CNT_W'(STEPS - 1));
  assign load_o    = (state_q == MS_IDLE) && start_i;
  assign step_o    = (state_q == MS_RUN);
  assign done_o    = (state_q == MS_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        MS_IDLE: begin
          if (start_i) begin
            state_q <= MS_RUN;
            cnt_q   <= '0;
          end
        end
        MS_RUN: begin
          if (last_step) begin
            state_q <= MS_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        MS_HOLD: begin
          if (!start_i) state_q <= MS_IDLE;
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  // R4
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> done_o);

  // R5
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (!done_o && !step_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !step_o && !start_i) |=> (!done_o && !step_o));

  // R2
  last_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(step_o));

endmodule

// File: rtl/mul_pp_sum.sv
module mul_pp_sum #(
  parameter int unsigned RES_W        = 32,
  parameter int unsigned ADDS_PER_CYC = 1
) (
  input  logic [RES_W-1:0]        mcand_i,
  input  logic [ADDS_PER_CYC-1:0] bits_i,
  output logic [RES_W-1:0]        sum_o
);

  logic [RES_W-1:0] pp [ADDS_PER_CYC];

  for (genvar j = 0; j < ADDS_PER_CYC; j++) begin : g_pp
    assign pp[j] = bits_i[j] ? (mcand_i << j) : '0;
  end

  always_comb begin
    sum_o = '0;
    for (int j = 0; j < ADDS_PER_CYC; j++) sum_o = sum_o + pp[j];
  end

endmodule

// File: rtl/mul_acc.sv
module mul_acc #(
  parameter int unsigned OP_W         = 16,
  parameter int unsigned ADDS_PER_CYC = 1,
  localparam int unsigned RES_W = 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [RES_W-1:0] result_o
);

  logic [RES_W-1:0] mcand_q;
  logic [OP_W-1:0]  mplier_q;
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] addend;

  mul_pp_sum #(
    .RES_W       (RES_W),
    .ADDS_PER_CYC(ADDS_PER_CYC)
  ) i_pp_sum (
    .mcand_i(mcand_q),
    .bits_i (mplier_q[ADDS_PER_CYC-1:0]),
    .sum_o  (addend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= {{OP_W{1'b0}}, a_i};
      mplier_q <= b_i;
      acc_q    <= '0;
    end else if (step_i) begin
      acc_q    <= acc_q + addend;
      mcand_q  <= mcand_q << ADDS_PER_CYC;
      mplier_q <= mplier_q >> ADDS_PER_CYC;
    end
  end

  assign result_o = acc_q;

  // R1: a step whose selected multiplier bits are all zero leaves the sum alone
  zero_bits_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (mplier_q[ADDS_PER_CYC-1:0] == '0)) |=> $stable(result_o));

  // R4: the sum is frozen outside capture and accumulation
  acc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(result_o));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned OP_W         = 16,
  parameter int unsigned ADDS_PER_CYC = 1,
  localparam int unsigned RES_W = 2 * OP_W,
  localparam int unsigned STEPS = OP_W / ADDS_PER_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  logic load, step;

  mul_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .done_o (done_o)
  );

  mul_acc #(
    .OP_W        (OP_W),
    .ADDS_PER_CYC(ADDS_PER_CYC)
  ) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .a_i     (a_i),
    .b_i     (b_i),
    .result_o(result_o)
  );

  // Checker state: operands seen at capture and edges since capture
  logic [OP_W-1:0] chk_a_q, chk_b_q;
  logic [7:0]      chk_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_a_q   <= '0;
      chk_b_q   <= '0;
      chk_lat_q <= '0;
    end else if (load) begin
      chk_a_q   <= a_i;
      chk_b_q   <= b_i;
      chk_lat_q <= '0;
    end else if (chk_lat_q != 8'hFF) begin
      chk_lat_q <= chk_lat_q + 8'd1;
    end
  end

  // R1
  product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o == ({{OP_W{1'b0}}, chk_a_q} * {{OP_W{1'b0}}, chk_b_q})));

  // R2 R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (chk_lat_q == 8'(STEPS)));

endmodule

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st1 = 1'b0, st2 = 1'b0;
  logic [15:0] a1 = '0, b1 = '0, a2 = '0, b2 = '0;
  logic [31:0] res1, res2;
  logic        done1, done2;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  shift_add_mul #(.OP_W(16), .ADDS_PER_CYC(1)) i_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(st1), .a_i(a1), .b_i(b1),
    .result_o(res1), .done_o(done1)
  );

  shift_add_mul #(.OP_W(16), .ADDS_PER_CYC(2)) i_shift_add_mul_dual (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(st2), .a_i(a2), .b_i(b2),
    .result_o(res2), .done_o(done2)
  );

  localparam logic [31:0] VEC [8] = '{
    {16'h3524, 16'h5E81}, {16'hAAAA, 16'h5555}, {16'h00FF, 16'hFF00},
    {16'h8000, 16'h8000}, {16'h0001, 16'hFFFF}, {16'hD609, 16'h5663},
    {16'h7B0D, 16'h998D}, {16'hFFFF, 16'h0002}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic get_done(input int sel);
    return (sel == 1) ? done1 : done2;
  endfunction

  function automatic logic [31:0] get_res(input int sel);
    return (sel == 1) ? res1 : res2;
  endfunction

  task automatic drive(input int sel, input logic st, input logic [15:0] a, input logic [15:0] b);
    if (sel == 1) begin st1 = st; a1 = a; b1 = b; end
    else          begin st2 = st; a2 = a; b2 = b; end
  endtask

  // Called at a negedge; leaves off at the negedge where done was seen low.
  task automatic do_op(input int sel, input logic [15:0] a, input logic [15:0] b,
                       input bit early_release, input bit scramble, input string rtag);
    logic [31:0] exp;
    int          n;
    int          lat_exp;
    exp     = {16'b0, a} * {16'b0, b};
    lat_exp = (sel == 1) ? 17 : 9;
    drive(sel, 1'b1, a, b);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (scramble && n == 1) drive(sel, 1'b1, ~a, ~b);
      if (get_done(sel) || n > 60) break;
    end
    chk(n == lat_exp, (sel == 1) ? "R2 latency" : "R3 latency", 32'(n), 32'(lat_exp));
    chk(get_res(sel) == exp, rtag, get_res(sel), exp);
    if (!early_release) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(get_done(sel) === 1'b1, "R4 done held", 32'(get_done(sel)), 32'd1);
        chk(get_res(sel) == exp, "R4 result stable", get_res(sel), exp);
      end
    end
    drive(sel, 1'b0, scramble ? ~a : a, scramble ? ~b : b);
    @(negedge clk);
    chk(get_done(sel) === 1'b0, "R5 done release", 32'(get_done(sel)), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done1 === 1'b0, "R7 reset done", 32'(done1), 32'd0);
    chk(res1 === 32'd0, "R7 reset result", res1, 32'd0);
    chk(done2 === 1'b0, "R7 reset done dual", 32'(done2), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 vector table on both widths
    for (int i = 0; i < 8; i++) begin
      do_op(1, VEC[i][31:16], VEC[i][15:0], 1'b0, 1'b0, "R1 product");
      do_op(2, VEC[i][31:16], VEC[i][15:0], 1'b0, 1'b0, "R1 product dual");
    end

    // R5 release on the done edge, then back-to-back restart
    do_op(1, 16'h1234, 16'h5678, 1'b1, 1'b0, "R5 early release product");
    do_op(1, 16'h0F0F, 16'hF0F0, 1'b0, 1'b0, "R5 restart product");
    do_op(2, 16'h1234, 16'h5678, 1'b1, 1'b0, "R5 early release product dual");
    do_op(2, 16'h0F0F, 16'hF0F0, 1'b0, 1'b0, "R5 restart product dual");

    // R6 operands changed after capture
    do_op(1, 16'hC3A5, 16'h9E37, 1'b0, 1'b1, "R6 scramble ignored");
    do_op(2, 16'hC3A5, 16'h9E37, 1'b0, 1'b1, "R6 scramble ignored dual");

    // R8 corners
    do_op(1, 16'h0000, 16'h0000, 1'b0, 1'b0, "R8 zero");
    do_op(1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R8 all ones");
    do_op(2, 16'h0000, 16'hFFFF, 1'b0, 1'b0, "R8 zero dual");
    do_op(2, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R8 all ones dual");

    // R9 idle with start low
    held = res1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done1 === 1'b0, "R9 idle done", 32'(done1), 32'd0);
      chk(res1 == held, "R9 idle result", res1, held);
    end

    // R7 reset in mid-operation
    drive(1, 1'b1, 16'hFFFF, 16'hFFFF);
    repeat (6) @(negedge clk);
    rst_ni = 1'b0;
    drive(1, 1'b0, 16'h0000, 16'h0000);
    #1;
    chk(res1 === 32'd0, "R7 mid-op reset result", res1, 32'd0);
    chk(done1 === 1'b0, "R7 mid-op reset done", 32'(done1), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    do_op(1, 16'h0003, 16'h0005, 1'b0, 1'b0, "R7 product after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule